// File: doc/BRIEF.md
# Global-History Per-Address Two-Level Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps two levels of state. The first level is a shift register of the most recent global branch outcomes. The second level is a group of pattern tables of saturating counters, one table for each possible history value. When a branch is looked up, the current history picks a table and the low bits of the branch address pick a counter inside that table. The top bit of that counter is the prediction.

The lookup path is combinational. It returns the prediction and the history value that was used for it. The fetch logic carries that history value along with the branch. When the branch resolves, the fetch logic presents the same address, the carried history and the real outcome on the resolve port. On the next clock edge the selected counter steps towards the outcome and the outcome is shifted into the global history. With the history width set to zero the block becomes a single table of counters indexed by address only.

Top module: `gap_predictor`

## Requirements
- R1: After a synchronous active-low reset the history output reads 0 and every counter holds the weakly not-taken value (binary 01 for two-bit counters). Every lookup then predicts not-taken, and a single taken update makes that entry predict taken.
- R2: When a resolve is applied, the history becomes the old history shifted up by one bit, with the new outcome in bit 0 (1 = taken) and the oldest bit dropped.
- R3: A lookup uses the current history to choose the pattern table, and `pred_hist` shows that history value.
- R4: Within a table, only the low `IDX_W` address bits choose the counter. Two addresses that share those bits read and update the same counter.
- R5: A resolve with outcome taken adds one to the selected counter. A resolve with outcome not-taken subtracts one.
- R6: A counter saturates. Taken at the maximum value and not-taken at zero leave it unchanged.
- R7: `pred_taken` equals the top bit of the selected counter.
- R8: An update writes the counter in the table named by `res_hist`, not in the table named by the current history.
- R9: While `res_valid` is low, neither the history nor any counter changes.
- R10: A lookup in the same cycle as a resolve returns the state from before that resolve.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pred_pc | input | PC_W | Branch address to look up |
| pred_taken | output | 1 | Prediction: 1 = taken |
| pred_hist | output | HIST_W (at least 1) | History used for this lookup |
| res_valid | input | 1 | A resolved branch is presented this cycle |
| res_pc | input | PC_W | Address of the resolved branch |
| res_hist | input | HIST_W (at least 1) | History captured at lookup time |
| res_taken | input | 1 | Real outcome: 1 = taken |

## Verification
The bench trains counters up to the maximum and down to zero. A counter that wraps instead of saturating would turn a strong taken into a not-taken prediction after one extra taken outcome. It resolves branches with a history that differs from the current one. A design that indexed the update with the live register would train the wrong table, and later lookups under the carried history would disagree. It also uses addresses that differ only above the index bits, applies a lookup and a resolve in the same cycle, idles the resolve port, and applies reset after training. These catch a design that decodes too many address bits, reads the post-update value, updates on an idle cycle, or fails to restore the weak initial state.

// File: rtl/gap_pkg.sv
// Package gap_pkg
// Shared helpers for the two-level predictor: the saturating counter step and
// the weak not-taken reset value. Assumes counter widths of 1 to 31 bits.
package gap_pkg;

    // Move a counter one step towards the outcome, holding at 0 and at maxv.
    function automatic int unsigned sat_step(input int unsigned cur,
                                             input int unsigned maxv,
                                             input logic up);
        if (up) begin
            return (cur >= maxv) ? maxv : cur + 1;
        end
        return (cur == 0) ? 0 : cur - 1;
    endfunction

    // Weakly not-taken value: the largest count whose top bit is still 0.
    function automatic int unsigned weak_nt(input int unsigned width);
        return (width <= 1) ? 0 : ((1 << (width - 1)) - 1);
    endfunction

endpackage

// File: rtl/gap_history.sv
// Module gap_history
// First predictor level: an HIST_W-bit shift register of global outcomes.
// The newest outcome enters bit 0 and the oldest leaves from the top bit.
// Assumes HIST_W >= 0. HW is the port width, at least 1. With HIST_W == 0
// the output is a constant zero.
module gap_history #(
    parameter int HIST_W = 2,
    parameter int HW     = (HIST_W > 0) ? HIST_W : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd_en,
    input  logic          upd_taken,
    output logic [HW-1:0] hist_q
);

    generate
        if (HIST_W == 0) begin : g_none
            assign hist_q = '0;
        end else if (HIST_W == 1) begin : g_one
            // Hold the single most recent outcome.
            always_ff @(posedge clk) begin
                if (!rst_n)      hist_q <= '0;
                else if (upd_en) hist_q <= upd_taken;
            end
        end else begin : g_shift
            // Shift the resolved outcome in at bit 0.
            always_ff @(posedge clk) begin
                if (!rst_n)      hist_q <= '0;
                else if (upd_en) hist_q <= {hist_q[HIST_W-2:0], upd_taken};
            end

            p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
                upd_en |=> hist_q == {$past(hist_q[HIST_W-2:0]), $past(upd_taken)});

            p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
                !upd_en |=> $stable(hist_q));
        end
    endgenerate

endmodule

// File: rtl/gap_pattern_bank.sv
// Module gap_pattern_bank
// Second predictor level: 2^HIST_W tables of 2^IDX_W saturating counters,
// stored flat and addressed by {history, address index}. One read port and
// one write port. A read in the same cycle as a write sees the old value.
// Assumes 1 <= CTR_W <= 31.
module gap_pattern_bank
    import gap_pkg::*;
#(
    parameter int HIST_W = 2,
    parameter int IDX_W  = 4,
    parameter int CTR_W  = 2,
    parameter int HW     = (HIST_W > 0) ? HIST_W : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [HW-1:0]    rd_hist,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CTR_W-1:0] rd_ctr,
    input  logic             wr_en,
    input  logic [HW-1:0]    wr_hist,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);

    localparam int SEL_W   = HIST_W + IDX_W;
    localparam int ENTRIES = 1 << SEL_W;
    localparam int unsigned CTR_MAX = (1 << CTR_W) - 1;
    localparam logic [CTR_W-1:0] CTR_INIT = CTR_W'(weak_nt(CTR_W));

    logic [ENTRIES-1:0][CTR_W-1:0] ctr_q;
    logic [SEL_W-1:0]              rd_sel;
    logic [SEL_W-1:0]              wr_sel;
    logic [CTR_W-1:0]              wr_cur;
    logic [CTR_W-1:0]              wr_nxt;

    // Pick the table with history bits and the entry with address bits.
    generate
        if (HIST_W == 0) begin : g_flat
            assign rd_sel = rd_idx;
            assign wr_sel = wr_idx;
        end else begin : g_tables
            assign rd_sel = {rd_hist[HIST_W-1:0], rd_idx};
            assign wr_sel = {wr_hist[HIST_W-1:0], wr_idx};
        end
    endgenerate

    // Read the selected counter and work out the next value of the written one.
    always_comb begin
        rd_ctr = ctr_q[rd_sel];
        wr_cur = ctr_q[wr_sel];
        wr_nxt = CTR_W'(sat_step(int'(wr_cur), CTR_MAX, wr_taken));
    end

    // Reset every counter to weakly not-taken, then write one counter per resolve.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= CTR_INIT;
        end else if (wr_en) begin
            ctr_q[wr_sel] <= wr_nxt;
        end
    end

    p_step_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_taken && (wr_cur != CTR_W'(CTR_MAX)) |=>
        ctr_q[$past(wr_sel)] == $past(wr_cur) + 1'b1);

    p_step_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_taken && (wr_cur != '0) |=>
        ctr_q[$past(wr_sel)] == $past(wr_cur) - 1'b1);

    p_sat_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_taken && (wr_cur == CTR_W'(CTR_MAX)) |=>
        ctr_q[$past(wr_sel)] == CTR_W'(CTR_MAX));

    p_sat_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_taken && (wr_cur == '0) |=> ctr_q[$past(wr_sel)] == '0);

    p_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctr_q));

endmodule

// File: rtl/gap_predictor.sv
// Module gap_predictor
// Two-level correlating branch direction predictor. The global history picks
// one of 2^HIST_W counter tables and the low IDX_W address bits pick the
// counter. The top counter bit is the prediction. A resolve updates the
// counter named by the history carried from lookup time and shifts the
// outcome into the global history. Assumes IDX_W <= PC_W.
module gap_predictor #(
    parameter int PC_W   = 16,
    parameter int HIST_W = 2,
    parameter int IDX_W  = 4,
    parameter int CTR_W  = 2,
    parameter int HW     = (HIST_W > 0) ? HIST_W : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] pred_pc,
    output logic            pred_taken,
    output logic [HW-1:0]   pred_hist,
    input  logic            res_valid,
    input  logic [PC_W-1:0] res_pc,
    input  logic [HW-1:0]   res_hist,
    input  logic            res_taken
);

    logic [HW-1:0]    hist_now;
    logic [CTR_W-1:0] sel_ctr;

    gap_history #(
        .HIST_W (HIST_W),
        .HW     (HW)
    ) i_history (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_en    (res_valid),
        .upd_taken (res_taken),
        .hist_q    (hist_now)
    );

    gap_pattern_bank #(
        .HIST_W (HIST_W),
        .IDX_W  (IDX_W),
        .CTR_W  (CTR_W),
        .HW     (HW)
    ) i_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_hist  (hist_now),
        .rd_idx   (pred_pc[IDX_W-1:0]),
        .rd_ctr   (sel_ctr),
        .wr_en    (res_valid),
        .wr_hist  (res_hist),
        .wr_idx   (res_pc[IDX_W-1:0]),
        .wr_taken (res_taken)
    );

    // Drive the lookup results from the live history and the selected counter.
    always_comb begin
        pred_hist  = hist_now;
        pred_taken = sel_ctr[CTR_W-1];
    end

    p_lookup_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(res_valid) && $stable(pred_pc) |-> $stable(pred_taken) && $stable(pred_hist));

    p_res_known_r4: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !$isunknown({res_pc, res_hist, res_taken}));

    p_pred_known_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(pred_pc) |-> !$isunknown(pred_taken));

endmodule

// File: tb/test_gap_predictor.sv
`timescale 1ns/1ps
// Self-checking bench: a reference model built from the requirements,
// a vector table walked by one loop, then directed corner cases.
module test_gap_predictor;

    localparam int PC_W   = 16;
    localparam int HIST_W = 2;
    localparam int IDX_W  = 4;
    localparam int CTR_W  = 2;
    localparam int ENT    = 1 << (HIST_W + IDX_W);
    localparam int CMAX   = (1 << CTR_W) - 1;

    typedef struct packed {
        logic [15:0] pc;
        logic        tk;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{16'h0010, 1'b1}, '{16'h0013, 1'b1}, '{16'h0010, 1'b1}, '{16'h0013, 1'b0},
        '{16'h0105, 1'b1}, '{16'h0005, 1'b1}, '{16'h0105, 1'b1}, '{16'h0005, 1'b0},
        '{16'hFFF7, 1'b0}, '{16'h0007, 1'b0}, '{16'h0010, 1'b1}, '{16'h0010, 1'b1},
        '{16'h0010, 1'b1}, '{16'h0010, 1'b1}, '{16'h2A0C, 1'b1}, '{16'h000C, 1'b0},
        '{16'h000C, 1'b1}, '{16'h1235, 1'b0}, '{16'h0005, 1'b1}, '{16'h0013, 1'b1}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [PC_W-1:0]   pred_pc = '0;
    logic              pred_taken;
    logic [HIST_W-1:0] pred_hist;
    logic              res_valid = 1'b0;
    logic [PC_W-1:0]   res_pc = '0;
    logic [HIST_W-1:0] res_hist = '0;
    logic              res_taken = 1'b0;

    int n_vec = 0;
    int n_bad = 0;
    int cyc   = 0;
    int mctr [ENT];
    logic [HIST_W-1:0] mhist;

    gap_predictor #(
        .PC_W   (PC_W),
        .HIST_W (HIST_W),
        .IDX_W  (IDX_W),
        .CTR_W  (CTR_W)
    ) i_gap_predictor (
        .clk        (clk),
        .rst_n      (rst_n),
        .pred_pc    (pred_pc),
        .pred_taken (pred_taken),
        .pred_hist  (pred_hist),
        .res_valid  (res_valid),
        .res_pc     (res_pc),
        .res_hist   (res_hist),
        .res_taken  (res_taken)
    );

    always #2 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<=20000", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int midx(input logic [PC_W-1:0] pc, input logic [HIST_W-1:0] h);
        return int'({h, pc[IDX_W-1:0]});
    endfunction

    task automatic model_reset();
        mhist = '0;
        for (int i = 0; i < ENT; i++) mctr[i] = 1;   // weak not-taken, R1
    endtask

    // One cycle: drive lookup and (optionally) resolve together at the falling
    // edge, check the lookup against the pre-update model (R3, R7, R10), then
    // let the rising edge apply the resolve and update the model.
    task automatic step(input string tag, input logic [PC_W-1:0] pc, input logic tk,
                        input logic vld, input logic ovr, input logic [HIST_W-1:0] hov);
        logic [HIST_W-1:0] uh;
        @(negedge clk);
        uh        = ovr ? hov : mhist;
        pred_pc   = pc;
        res_valid = vld;
        res_pc    = pc;
        res_taken = tk;
        res_hist  = uh;
        #0.5;
        chk({tag, " R3 hist"}, int'(pred_hist), int'(mhist));
        chk({tag, " R7 pred"}, int'(pred_taken), (mctr[midx(pc, mhist)] >= 2) ? 1 : 0);
        @(posedge clk);
        #0.2;
        res_valid = 1'b0;
        if (vld) begin
            int k = midx(pc, uh);
            if (tk)  mctr[k] = (mctr[k] == CMAX) ? CMAX : mctr[k] + 1;   // R5 R6
            else     mctr[k] = (mctr[k] == 0) ? 0 : mctr[k] - 1;
            mhist = {mhist[HIST_W-2:0], tk};                              // R2
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        res_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    initial begin
        model_reset();
        do_reset();

        // R1: every entry of table 0 predicts not-taken, history is zero.
        for (int p = 0; p < (1 << IDX_W); p++) step("R1 reset", PC_W'(p), 1'b0, 1'b0, 1'b0, '0);

        // Vector table walked by one loop (R2 R4 R5 R7 R10 via the model).
        for (int v = 0; v < NV; v++) step("R4 R5 vec", VECS[v].pc, VECS[v].tk, 1'b1, 1'b0, '0);

        // R6: drive one counter in table 0 above the top and then below zero.
        do_reset();
        for (int i = 0; i < 5; i++) step("R6 top", 16'h0009, 1'b1, 1'b1, 1'b1, 2'b00);
        chk("R6 model top", mctr[9], CMAX);
        for (int i = 0; i < 2; i++) step("R6 nt", 16'h000A, 1'b0, 1'b1, 1'b0, '0);
        // history now 00: one not-taken after saturation must still predict taken
        chk("R6 hist00", int'(mhist), 0);
        step("R6 strong", 16'h0009, 1'b0, 1'b1, 1'b1, 2'b00);
        for (int i = 0; i < 2; i++) step("R6 nt2", 16'h000A, 1'b0, 1'b1, 1'b0, '0);
        step("R6 still T", 16'h0009, 1'b0, 1'b0, 1'b0, '0);
        chk("R6 pred after one nt", int'(pred_taken), 1);
        for (int i = 0; i < 4; i++) step("R6 floor", 16'h0009, 1'b0, 1'b1, 1'b1, 2'b00);
        chk("R6 model floor", mctr[9], 0);

        // R8: update table 3 while the live history is 00; table 0 unchanged.
        do_reset();
        step("R8 upd", 16'h0004, 1'b1, 1'b1, 1'b1, 2'b11);
        step("R8 upd", 16'h0004, 1'b0, 1'b1, 1'b1, 2'b11);   // hist 10
        step("R8 upd", 16'h0004, 1'b0, 1'b1, 1'b1, 2'b11);   // hist 00
        step("R8 t0", 16'h0004, 1'b1, 1'b1, 1'b0, '0);       // table 0 still weak NT, hist 01
        step("R8 upd", 16'h0004, 1'b1, 1'b1, 1'b1, 2'b11);   // hist 11
        step("R8 t3", 16'h0004, 1'b0, 1'b0, 1'b0, '0);       // reads table 3 entry 4
        chk("R8 table3 trained", int'(pred_taken), (mctr[midx(16'h0004, 2'b11)] >= 2) ? 1 : 0);

        // R9: idle resolve port changes nothing.
        for (int i = 0; i < 3; i++) step("R9 idle", 16'h0004, 1'b1, 1'b0, 1'b0, '0);
        chk("R9 hist held", int'(pred_hist), 3);

        // R10: lookup and resolve on the same entry in one cycle.
        step("R10 same", 16'h0004, 1'b0, 1'b1, 1'b0, '0);

        // R1: reset after training restores all of table 0 to not-taken.
        do_reset();
        for (int p = 0; p < (1 << IDX_W); p++) step("R1 rereset", PC_W'(p) | 16'h0300, 1'b0, 1'b0, 1'b0, '0);
        step("R1 one T", 16'h0002, 1'b1, 1'b1, 1'b1, 2'b01);
        step("R1 one T", 16'h0002, 1'b1, 1'b0, 1'b0, '0);
        chk("R1 weak flips", int'(pred_taken), 1);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule